// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block is a periodic tick source. A down-counter loses one per selected tick. When it is at zero, the next tick reloads it from a programmable reload register, so the period is the reload value plus one tick. When the count falls from one to zero, the block sets a sticky wrap flag. If interrupts are enabled, it also raises a one-cycle interrupt request. The counter is `CNT_W` bits wide, 24 by default, so the largest reload value is 2^CNT_W − 1.

Software reaches the block through a word-addressed register port with no wait states. Read data is combinational from the address, and a read takes effect (its strobe) only when `bus_sel` is high and `bus_wr` is low. The registers are:

| Offset | Register | Contents |
|---|---|---|
| 0x0 | control/status | bit 0 run, bit 1 interrupt enable, bit 2 source select, bit 16 wrap flag |
| 0x4 | reload | reload value |
| 0x8 | current count | current count |

Source select 1 counts on every core clock. Source select 0 counts only in cycles where the `ref_tick` enable pulse is high. The usual setup sequence is: stop, write the reload value, clear the count, pick the source, set the interrupt enable, then set run.

A small state machine sequences the counter. Its states are:
- HALT: run is clear, and the counter holds.
- PRIME: running with the count at zero, so the next tick loads the reload value.
- DOWN: running with a non-zero count.

Its transitions are:
- Any state goes to HALT when run is clear.
- A clear write while running goes to PRIME.
- HALT goes to PRIME or DOWN when run is set, depending on whether the count is zero.
- PRIME goes to DOWN on a tick that loads a non-zero value. With a reload of zero it stays in PRIME.
- DOWN goes to PRIME on the tick that takes the count from one to zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current registers read 0 and `irq` is low.
- R2: The control register keeps bits 0 (run), 1 (interrupt enable) and 2 (source select) as written, and reads 0 in all other bits except bit 16. The reload register reads back only its low CNT_W bits.
- R3: With run=1 and source select=1, the count changes on every clock. Counting from a count of 0, the value after n ticks is R − ((n−1) mod (R+1)) for reload value R, so the period is R+1 ticks.
- R4: With run=1 and source select=0, the count changes only on clocks where `ref_tick` is 1, and follows the same sequence as R3.
- R5: A tick while the count is 0 loads the reload value rather than decrementing.
- R6: Any write to offset 0x8 sets the count to 0 and clears the wrap flag, whatever the data. It takes priority over a tick in the same cycle.
- R7: With run=0, the count holds its value.
- R8: The wrap flag (bit 16 of offset 0x0) reads 1 from the cycle after a tick takes the count from 1 to 0. A read strobe on offset 0x0 clears it. If a wrap happens in the same cycle as that read, the flag is set.
- R9: `irq` is high for exactly the one cycle after a 1-to-0 tick when the interrupt enable is 1, and is low otherwise.
- R10: With reload value 0, a count of 0 stays 0 and produces no wrap flag and no `irq`.
- R11: Offsets other than 0x0, 0x4 and 0x8 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ref_tick | input | 1 | Reference tick enable, one core clock wide |
| irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
Two pairs of functions can act in the same clock cycle.

The first pair is the tick that takes the count from one to zero and a read strobe on the control register. The bench starts the read one cycle before that tick, so both land on the same clock edge. It then reads the flag again without a strobe and expects it to be 1, because the set must win.

The second pair is a clear write and a tick. The bench writes offset 0x8 while counting on every clock. It expects 0, and not the decremented value, in the next cycle, and the reload value in the cycle after that.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned BUS_W        = 32;
    localparam int unsigned CTL_RUN_BIT  = 0;
    localparam int unsigned CTL_IRQ_BIT  = 1;
    localparam int unsigned CTL_SRC_BIT  = 2;
    localparam int unsigned CTL_FLAG_BIT = 16;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_PRIME = 2'd1,
        ST_DOWN  = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_DEC  = 2'd2,
        OP_CLR  = 2'd3
    } cnt_op_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_RLD  = 2'd1,
        REG_CUR  = 2'd2,
        REG_NONE = 2'd3
    } reg_idx_e;

endpackage

// File: rtl/tt_bus_regs.sv
module tt_bus_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              flag,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              ctl_run,
    output logic              ctl_irq_en,
    output logic              ctl_core,
    output logic [CNT_W-1:0]  rld_q,
    output logic              clr_wr,
    output logic              rd_ctl
);

    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_RLD  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_CUR  = ADDR_W'(8);

    reg_idx_e idx;
    logic     wr_ev;
    logic     rd_ev;
    logic     unused_wdata;

    // Address decode: only the three word offsets are mapped.
    always_comb begin
        if (bus_addr == OFF_CTRL)      idx = REG_CTRL;
        else if (bus_addr == OFF_RLD)  idx = REG_RLD;
        else if (bus_addr == OFF_CUR)  idx = REG_CUR;
        else                           idx = REG_NONE;
    end

    assign wr_ev        = bus_sel & bus_wr;
    assign rd_ev        = bus_sel & ~bus_wr;
    assign clr_wr       = wr_ev & (idx == REG_CUR);
    assign rd_ctl       = rd_ev & (idx == REG_CTRL);
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_run    <= 1'b0;
            ctl_irq_en <= 1'b0;
            ctl_core   <= 1'b0;
        end else if (wr_ev && idx == REG_CTRL) begin
            ctl_run    <= bus_wdata[CTL_RUN_BIT];
            ctl_irq_en <= bus_wdata[CTL_IRQ_BIT];
            ctl_core   <= bus_wdata[CTL_SRC_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_ev && idx == REG_RLD) begin
            rld_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            REG_CTRL: begin
                bus_rdata[CTL_RUN_BIT]  = ctl_run;
                bus_rdata[CTL_IRQ_BIT]  = ctl_irq_en;
                bus_rdata[CTL_SRC_BIT]  = ctl_core;
                bus_rdata[CTL_FLAG_BIT] = flag;
            end
            REG_RLD:  bus_rdata = BUS_W'(rld_q);
            REG_CUR:  bus_rdata = BUS_W'(cnt_val);
            REG_NONE: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tt_down_fsm.sv
module tt_down_fsm
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             core_sel,
    input  logic             ref_tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] rld,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_evt
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    cnt_state_e state_q;
    cnt_state_e state_d;
    cnt_op_e    op;
    logic       adv;

    assign adv = run & (core_sel | ref_tick);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Output decode: counter operation for this cycle.
    always_comb begin
        op = OP_HOLD;
        if (clr) begin
            op = OP_CLR;
        end else if (adv) begin
            unique case (state_q)
                ST_HALT:  op = (cnt_q == CNT_ZERO) ? OP_LOAD : OP_DEC;
                ST_PRIME: op = OP_LOAD;
                ST_DOWN:  op = OP_DEC;
                default:  op = OP_HOLD;
            endcase
        end
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_HALT;
        end else begin
            unique case (op)
                OP_CLR:  state_d = ST_PRIME;
                OP_LOAD: state_d = (rld == CNT_ZERO) ? ST_PRIME : ST_DOWN;
                OP_DEC:  state_d = (cnt_q == CNT_ONE) ? ST_PRIME : ST_DOWN;
                OP_HOLD: begin
                    if (state_q == ST_HALT)
                        state_d = (cnt_q == CNT_ZERO) ? ST_PRIME : ST_DOWN;
                end
            endcase
        end
    end

    // Count datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                OP_CLR:  cnt_q <= '0;
                OP_LOAD: cnt_q <= rld;
                OP_DEC:  cnt_q <= cnt_q - CNT_ONE;
                OP_HOLD: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wrap_evt = (op == OP_DEC) && (cnt_q == CNT_ONE);

endmodule

// File: rtl/tt_event.sv
module tt_event (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_evt,
    input  logic rd_ctl,
    input  logic clr_wr,
    input  logic irq_en,
    output logic flag_q,
    output logic irq_q
);

    // A wrap in the same cycle as a clearing read leaves the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (wrap_evt)         flag_q <= 1'b1;
        else if (rd_ctl || clr_wr) flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap_evt & irq_en;
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ref_tick,
    output logic              irq
);

    logic             ctl_run;
    logic             ctl_irq_en;
    logic             ctl_core;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_wr;
    logic             rd_ctl;
    logic             wrap_evt;
    logic             flag_q;
    logic             irq_q;

    tt_bus_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_val    (cnt_q),
        .flag       (flag_q),
        .bus_rdata  (bus_rdata),
        .ctl_run    (ctl_run),
        .ctl_irq_en (ctl_irq_en),
        .ctl_core   (ctl_core),
        .rld_q      (rld_q),
        .clr_wr     (clr_wr),
        .rd_ctl     (rd_ctl)
    );

    tt_down_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl_run),
        .core_sel (ctl_core),
        .ref_tick (ref_tick),
        .clr      (clr_wr),
        .rld      (rld_q),
        .cnt_q    (cnt_q),
        .wrap_evt (wrap_evt)
    );

    tt_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_evt (wrap_evt),
        .rd_ctl   (rd_ctl),
        .clr_wr   (clr_wr),
        .irq_en   (ctl_irq_en),
        .flag_q   (flag_q),
        .irq_q    (irq_q)
    );

    assign irq = irq_q;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_run,
    input logic             ctl_core,
    input logic             ctl_irq_en,
    input logic             ref_tick,
    input logic             clr_wr,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rld_q,
    input logic             flag_q,
    input logic             irq
);

    logic adv;
    assign adv = ctl_run & (ctl_core | ref_tick);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q > CNT_W'(1) && !clr_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_load_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == '0 && !clr_wr) |=> (cnt_q == $past(rld_q)));

    p_clear_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (cnt_q == '0 && !flag_q));

    p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !clr_wr) |=> $stable(cnt_q));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == CNT_W'(1) && !clr_wr) |=> flag_q);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ctl_irq_en) && $past(cnt_q) == CNT_W'(1)));

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_zero_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_q == '0 && cnt_q == '0) |=> (cnt_q == '0 && !irq));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_run    (ctl_run),
    .ctl_core   (ctl_core),
    .ctl_irq_en (ctl_irq_en),
    .ref_tick   (ref_tick),
    .clr_wr     (clr_wr),
    .cnt_q      (cnt_q),
    .rld_q      (rld_q),
    .flag_q     (flag_q),
    .irq        (irq)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

    localparam int unsigned W      = 6;
    localparam int unsigned AW     = 4;
    localparam int unsigned MAXRLD = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          ref_tick = 1'b0;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer #(.CNT_W(W), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Read without strobe: no side effect.
    task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Strobed read, consumes one clock edge.
    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic int unsigned model_val(input int unsigned r, input int unsigned t);
        if (t == 0) return 0;
        return r - ((t - 1) % (r + 1));
    endfunction

    // Sweep one reload value in one source mode.
    task automatic sweep(input int unsigned r, input bit core);
        logic [31:0] d;
        int unsigned t;
        bit last_tick;
        bit tick_in;
        string req;
        req = core ? "R3" : "R4";
        if (r == 0) req = "R10";
        wr(4'h0, 32'h0);
        wr(4'h4, r);
        wr(4'h8, 32'hDEAD_BEEF);
        wr(4'h0, {29'b0, core, 2'b11});
        t = 0;
        last_tick = 1'b0;
        for (int cyc = 0; cyc < 2 * int'(r + 1) + 6; cyc++) begin
            peek(4'h8, d);
            chk(req, d, model_val(r, t));
            chk("R9", {31'b0, irq},
                {31'b0, (last_tick && r > 0 && t > 0 && (t % (r + 1)) == 0)});
            tick_in = core ? 1'b1 : ((((cyc * 7) + int'(r)) % 5) < 3);
            ref_tick = core ? (cyc % 2 == 0) : tick_in;
            last_tick = tick_in;
            if (tick_in) t++;
            @(negedge clk);
        end
        ref_tick = 1'b0;
        wr(4'h0, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(4'h0, d); chk("R1", d, 32'h0);
        peek(4'h4, d); chk("R1", d, 32'h0);
        peek(4'h8, d); chk("R1", d, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);

        // R2: control fields and reload masking
        wr(4'h0, 32'hFFFF_FFFA);
        peek(4'h0, d); chk("R2", d, 32'h0000_0002);
        wr(4'h0, 32'h0000_0004);
        peek(4'h0, d); chk("R2", d, 32'h0000_0004);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF);
        peek(4'h4, d); chk("R2", d, MAXRLD);

        // R11: unmapped offsets
        wr(4'hC, 32'h1234_5677);
        wr(4'h2, 32'hFFFF_FFFF);
        peek(4'hC, d); chk("R11", d, 32'h0);
        peek(4'h2, d); chk("R11", d, 32'h0);
        peek(4'h4, d); chk("R11", d, MAXRLD);
        peek(4'h0, d); chk("R11", d, 32'h0);
        peek(4'h8, d); chk("R11", d, 32'h0);

        // R3 / R4 / R5 / R9 / R10: sweeps
        for (int r = 0; r < 8; r++) begin
            sweep(r, 1'b1);
            sweep(r, 1'b0);
        end
        sweep(MAXRLD, 1'b1);
        sweep(MAXRLD, 1'b0);

        // R7: stopped counter holds
        wr(4'h4, 32'd9);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h5);
        repeat (4) @(negedge clk);
        wr(4'h0, 32'h4);
        peek(4'h8, held);
        repeat (6) @(negedge clk);
        peek(4'h8, d); chk("R7", d, held);

        // R6: clear write wins over a same-cycle tick, next tick reloads
        wr(4'h4, 32'd5);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h5);
        repeat (2) @(negedge clk);
        wr(4'h8, 32'h0000_003F);
        peek(4'h8, d); chk("R6", d, 32'h0);
        @(negedge clk);
        peek(4'h8, d); chk("R5", d, 32'd5);
        wr(4'h0, 32'h4);

        // R8: flag set, cleared by strobed read
        wr(4'h4, 32'd3);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h5);
        repeat (7) @(negedge clk);
        wr(4'h0, 32'h4);
        rd(4'h0, d);
        chk("R8", d, 32'h0001_0004);
        peek(4'h0, d); chk("R8", d, 32'h0000_0004);

        // R6: clear write clears the flag
        wr(4'h0, 32'h5);
        repeat (7) @(negedge clk);
        wr(4'h0, 32'h4);
        peek(4'h0, d); chk("R8", d, 32'h0001_0004);
        wr(4'h8, 32'h0);
        peek(4'h0, d); chk("R6", d, 32'h0000_0004);

        // R8: wrap and clearing read on the same edge, set wins
        wr(4'h4, 32'd2);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h5);
        @(negedge clk);
        peek(4'h8, d); chk("R3", d, 32'd2);
        @(negedge clk);
        peek(4'h8, d); chk("R3", d, 32'd1);
        rd(4'h0, d);
        chk("R8", d, 32'h0000_0005);
        peek(4'h8, d); chk("R3", d, 32'd0);
        peek(4'h0, d); chk("R8", d, 32'h0001_0005);
        wr(4'h0, 32'h4);
        chk("R9", {31'b0, irq}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule